// File: doc/BRIEF.md
# Synchronized Serial Command Decoder

This block sits behind a UART receiver and turns its byte stream into register and memory accesses. A frame opens with the two sync bytes 0xFC then 0xF3. A command byte follows, and after it the address and data bytes that the command needs, most significant byte first. Each accepted command drives one of three things. It can write a 16-bit word on the memory port, fetch a 16-bit word from memory into two capture registers, or write a byte-wide register bank. A register read returns one byte to a UART transmitter through a valid/ready handshake. Frames that are malformed, have an unknown command, or stall too long are dropped without any access.

The controller has seven named states. In `ST_HUNT_A` it waits for 0xFC. In `ST_HUNT_B` it waits for 0xF3. In `ST_OPCODE` it takes the command byte, then collects bytes in `ST_ADDR` and `ST_DATA`. It waits for memory in `ST_MEM_WAIT` and holds a transmit byte in `ST_TX_HOLD`. The transitions are:

- HUNT_A→HUNT_B on 0xFC.
- HUNT_B→OPCODE on 0xF3, HUNT_B→HUNT_B on a repeated 0xFC, HUNT_B→HUNT_A on any other byte.
- OPCODE→ADDR on a known command, OPCODE→HUNT_A on an unknown one.
- ADDR→DATA when data bytes follow, ADDR→MEM_WAIT for a memory read, ADDR→TX_HOLD for a register read.
- DATA→HUNT_A on the last byte, which commits the write.
- MEM_WAIT→HUNT_A on read valid.
- TX_HOLD→HUNT_A on transmit ready.
- Any mid-frame state (HUNT_B, OPCODE, ADDR, DATA)→HUNT_A on gap timeout.

Top module: `sync_cmd_decoder`

## Requirements
- R1: A command byte is only taken right after 0xFC followed by 0xF3. Bytes outside such a frame cause no access. In HUNT_B, a 0xFC keeps the hunt waiting for 0xF3, and any other byte except 0xF3 returns to waiting for 0xFC.
- R2: Command 0x3B takes 2 address bytes and then 2 data bytes, each pair high byte first. `mem_wr_en` is high for exactly one cycle, in the cycle after the final byte is accepted. In that cycle `mem_addr` and `mem_wdata` carry the assembled values.
- R3: Consecutive write frames sent with no gap are accepted at one byte per cycle, with `rx_ready` high throughout.
- R4: Command 0x37 takes 2 address bytes and then raises `mem_rd_req` with `mem_addr` held until `mem_rd_valid`. While it waits, `rx_ready` is low. The returned low byte goes to register 0x25 and the high byte to register 0x26.
- R5: Command 0x68 takes 1 index byte and 1 data byte, and writes that byte to the register at that index.
- R6: Command 0x6A takes 1 index byte and 2 data bytes. The first data byte goes to the register at index+1 and the second to the register at index.
- R7: Command 0x60 takes 1 index byte and presents that register on `tx_data` with `tx_valid`. The byte is held unchanged, with `rx_ready` low, until `tx_ready`. Indexes at or above REG_N read as 0x00, and writes to them are dropped.
- R8: Any command byte other than 0x3B, 0x37, 0x68, 0x6A or 0x60 returns to waiting for 0xFC without any access.
- R9: Mid-frame, from the HUNT_B state through the last byte, `gap_limit` consecutive cycles with no byte abort the frame back to HUNT_A, and no access happens. A gap shorter than the limit does no harm. A `gap_limit` of 0 turns the timeout off.
- R10: After reset, `rx_ready` is 1, `tx_valid`, `mem_wr_en` and `mem_rd_req` are 0, and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Decoder takes a byte this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte is present |
| tx_ready | input | 1 | Transmitter takes the byte |
| mem_addr | output | ADDR_W | Memory address for write or read |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wr_en | output | 1 | One-cycle memory write strobe |
| mem_rd_req | output | 1 | Memory read request, held until valid |
| mem_rd_valid | input | 1 | Memory read data is present |
| mem_rd_data | input | DATA_W | Memory read data |
| gap_limit | input | GAP_W | Idle cycles allowed mid-frame, 0 turns the timeout off |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- the write strobe lasts one cycle and always comes right after an accepted byte;
- a memory request keeps its address until the read data returns;
- a pending transmit byte stays valid and unchanged;
- a gap timeout always lands the controller in HUNT_A.

Other rules depend on byte sequences, and only the bench scenarios show them:
- resynchronization on a repeated 0xFC;
- discarding of unknown commands and of stalled frames;
- the byte order in wide register writes and in the read capture;
- out-of-range indexes;
- back-to-back throughput.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam logic [7:0] SYNC_FIRST  = 8'hFC;
    localparam logic [7:0] SYNC_SECOND = 8'hF3;

    localparam logic [7:0] OP_MEM_WR   = 8'h3B;
    localparam logic [7:0] OP_MEM_RD   = 8'h37;
    localparam logic [7:0] OP_REG_WR8  = 8'h68;
    localparam logic [7:0] OP_REG_WR16 = 8'h6A;
    localparam logic [7:0] OP_REG_RD   = 8'h60;

    localparam logic [7:0] CAP_LO_IDX  = 8'h25;
    localparam logic [7:0] CAP_HI_IDX  = 8'h26;

    typedef enum logic [2:0] {
        ST_HUNT_A,
        ST_HUNT_B,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_MEM_WAIT,
        ST_TX_HOLD
    } scd_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MEM_WR,
        CMD_MEM_RD,
        CMD_REG_WR8,
        CMD_REG_WR16,
        CMD_REG_RD
    } scd_cmd_e;

    typedef struct packed {
        logic       known;
        scd_cmd_e   cmd;
        logic [1:0] n_addr;
        logic [1:0] n_data;
    } scd_shape_t;

    function automatic scd_shape_t shape_of(input logic [7:0] op);
        scd_shape_t s;
        s = '{known: 1'b0, cmd: CMD_NONE, n_addr: 2'd0, n_data: 2'd0};
        case (op)
            OP_MEM_WR:   s = '{known: 1'b1, cmd: CMD_MEM_WR,   n_addr: 2'd2, n_data: 2'd2};
            OP_MEM_RD:   s = '{known: 1'b1, cmd: CMD_MEM_RD,   n_addr: 2'd2, n_data: 2'd0};
            OP_REG_WR8:  s = '{known: 1'b1, cmd: CMD_REG_WR8,  n_addr: 2'd1, n_data: 2'd1};
            OP_REG_WR16: s = '{known: 1'b1, cmd: CMD_REG_WR16, n_addr: 2'd1, n_data: 2'd2};
            OP_REG_RD:   s = '{known: 1'b1, cmd: CMD_REG_RD,   n_addr: 2'd1, n_data: 2'd0};
            default:     s = '{known: 1'b0, cmd: CMD_NONE,     n_addr: 2'd0, n_data: 2'd0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scd_gap_timer.sv
module scd_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             byte_seen,
    input  logic [GAP_W-1:0] limit,
    output logic             expire
);

    logic [GAP_W-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!active || byte_seen) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    always_comb begin
        expire = active && !byte_seen && (limit != '0) && (idle_q == limit - 1'b1);
    end

endmodule

// File: rtl/scd_regbank.sv
module scd_regbank import scd_pkg::*; #(
    parameter int REG_N  = 64,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [7:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_byte
);

    localparam int IW = (REG_N > 1) ? $clog2(REG_N) : 1;

    logic [7:0] bank [REG_N];
    logic [8:0] wr_idx_next;

    assign wr_idx_next = {1'b0, wr_idx} + 9'd1;

    for (genvar i = 0; i < REG_N; i++) begin : g_cell
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (cap_en && (i == int'(CAP_LO_IDX))) begin
                cell_q <= cap_data[7:0];
            end else if (cap_en && (i == int'(CAP_HI_IDX))) begin
                cell_q <= cap_data[15:8];
            end else if (wr_en && (wr_idx == 8'(i))) begin
                cell_q <= wr_data[7:0];
            end else if (wr_en && wr_wide && (wr_idx_next == 9'(i))) begin
                cell_q <= wr_data[15:8];
            end
        end
        assign bank[i] = cell_q;
    end

    always_comb begin
        if (int'(rd_idx) < REG_N) begin
            rd_byte = bank[rd_idx[IW-1:0]];
        end else begin
            rd_byte = '0;
        end
    end

endmodule

// File: rtl/scd_frame_fsm.sv
module scd_frame_fsm import scd_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              byte_take,
    output logic              mid_frame,
    input  logic              gap_expire,
    input  logic              mem_rd_valid,
    input  logic              tx_ready,
    output logic              mem_rd_req,
    output logic              tx_valid,
    output logic              mem_wr_pulse,
    output logic              reg_wr_pulse,
    output logic              reg_wide,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    scd_state_e state_q, state_d;
    scd_cmd_e   cmd_q;
    scd_shape_t shape;
    logic [1:0] left_q;
    logic [1:0] ndata_q;
    logic       last_byte;

    assign shape     = shape_of(rx_data);
    assign last_byte = (left_q == 2'd1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT_A;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT_A: begin
                if (byte_take && rx_data == SYNC_FIRST) state_d = ST_HUNT_B;
            end
            ST_HUNT_B: begin
                if (gap_expire)                               state_d = ST_HUNT_A;
                else if (byte_take && rx_data == SYNC_SECOND) state_d = ST_OPCODE;
                else if (byte_take && rx_data == SYNC_FIRST)  state_d = ST_HUNT_B;
                else if (byte_take)                           state_d = ST_HUNT_A;
            end
            ST_OPCODE: begin
                if (gap_expire)     state_d = ST_HUNT_A;
                else if (byte_take) state_d = shape.known ? ST_ADDR : ST_HUNT_A;
            end
            ST_ADDR: begin
                if (gap_expire) begin
                    state_d = ST_HUNT_A;
                end else if (byte_take && last_byte) begin
                    if (ndata_q != 2'd0)          state_d = ST_DATA;
                    else if (cmd_q == CMD_MEM_RD) state_d = ST_MEM_WAIT;
                    else                          state_d = ST_TX_HOLD;
                end
            end
            ST_DATA: begin
                if (gap_expire)                  state_d = ST_HUNT_A;
                else if (byte_take && last_byte) state_d = ST_HUNT_A;
            end
            ST_MEM_WAIT: begin
                if (mem_rd_valid) state_d = ST_HUNT_A;
            end
            ST_TX_HOLD: begin
                if (tx_ready) state_d = ST_HUNT_A;
            end
            default: state_d = ST_HUNT_A;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        rx_ready   = state_q inside {ST_HUNT_A, ST_HUNT_B, ST_OPCODE, ST_ADDR, ST_DATA};
        mid_frame  = state_q inside {ST_HUNT_B, ST_OPCODE, ST_ADDR, ST_DATA};
        mem_rd_req = (state_q == ST_MEM_WAIT);
        tx_valid   = (state_q == ST_TX_HOLD);
        byte_take  = rx_valid && rx_ready;
    end

    // field collection and commit strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q        <= CMD_NONE;
            left_q       <= '0;
            ndata_q      <= '0;
            addr_q       <= '0;
            data_q       <= '0;
            mem_wr_pulse <= 1'b0;
            reg_wr_pulse <= 1'b0;
            reg_wide     <= 1'b0;
        end else begin
            mem_wr_pulse <= 1'b0;
            reg_wr_pulse <= 1'b0;
            if (byte_take && !gap_expire) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        if (shape.known) begin
                            cmd_q   <= shape.cmd;
                            left_q  <= shape.n_addr;
                            ndata_q <= shape.n_data;
                            addr_q  <= '0;
                            data_q  <= '0;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= {addr_q[ADDR_W-9:0], rx_data};
                        left_q <= last_byte ? ndata_q : left_q - 2'd1;
                    end
                    ST_DATA: begin
                        data_q <= {data_q[DATA_W-9:0], rx_data};
                        left_q <= left_q - 2'd1;
                        if (last_byte) begin
                            mem_wr_pulse <= (cmd_q == CMD_MEM_WR);
                            reg_wr_pulse <= (cmd_q == CMD_REG_WR8) || (cmd_q == CMD_REG_WR16);
                            reg_wide     <= (cmd_q == CMD_REG_WR16);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: write strobe is a single-cycle pulse
    a_r2_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_pulse |=> !mem_wr_pulse);

    // R4: pending read keeps request and address until data returns
    a_r4_rdreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(addr_q)));

    // R7: pending transmit byte stays offered until taken
    a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    // R9: a gap timeout from the timer always ends the frame in HUNT_A
    a_r9_abort_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        gap_expire |=> (state_q == ST_HUNT_A));

endmodule

// File: rtl/sync_cmd_decoder.sv
module sync_cmd_decoder import scd_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int REG_N  = 64,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wr_en,
    output logic              mem_rd_req,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic [GAP_W-1:0]  gap_limit
);

    logic              byte_take;
    logic              mid_frame;
    logic              gap_expire;
    logic              reg_wr_pulse;
    logic              reg_wide;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [7:0]        rd_byte;

    scd_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .byte_take    (byte_take),
        .mid_frame    (mid_frame),
        .gap_expire   (gap_expire),
        .mem_rd_valid (mem_rd_valid),
        .tx_ready     (tx_ready),
        .mem_rd_req   (mem_rd_req),
        .tx_valid     (tx_valid),
        .mem_wr_pulse (mem_wr_en),
        .reg_wr_pulse (reg_wr_pulse),
        .reg_wide     (reg_wide),
        .addr_q       (addr_q),
        .data_q       (data_q)
    );

    scd_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mid_frame),
        .byte_seen (byte_take),
        .limit     (gap_limit),
        .expire    (gap_expire)
    );

    scd_regbank #(.REG_N(REG_N), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_pulse),
        .wr_wide  (reg_wide),
        .wr_idx   (addr_q[7:0]),
        .wr_data  (data_q),
        .cap_en   (mem_rd_req && mem_rd_valid),
        .cap_data (mem_rd_data),
        .rd_idx   (addr_q[7:0]),
        .rd_byte  (rd_byte)
    );

    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = data_q;
        tx_data   = tx_valid ? rd_byte : 8'h00;
    end

    // R2: a write strobe only ever follows an accepted final byte
    a_r2_wr_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(rx_valid && rx_ready));

    // R7: the offered transmit byte does not change while it waits
    a_r7_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> $stable(tx_data));

endmodule

// File: tb/sim_sync_cmd_decoder.sv
module sim_sync_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_wr_en;
    logic        mem_rd_req;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = 16'h0000;
    logic [15:0] gap_limit = 16'd1000;

    int checks = 0;
    int errors = 0;
    int stalls = 0;

    typedef struct {
        int    kind;   // 0 mem write, 1 tx byte, 2 mem read request
        int    a;
        int    d;
        string req;
    } ev_t;
    ev_t sbq[$];

    always #2.5 clk = ~clk;

    sync_cmd_decoder u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wr_en    (mem_wr_en),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .gap_limit    (gap_limit)
    );

    function automatic logic [15:0] mem_model(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic expect_ev(input int kind, input int a, input int d, input string req);
        ev_t e;
        e.kind = kind; e.a = a; e.d = d; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor: compares produced events against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (mem_wr_en)              observe(0, int'(mem_addr), int'(mem_wdata));
                if (tx_valid && tx_ready)   observe(1, 0, int'(tx_data));
                if (mem_rd_req && mem_rd_valid) observe(2, int'(mem_addr), 0);
            end
        end
    end

    task automatic observe(input int kind, input int a, input int d);
        ev_t e;
        if (sbq.size() == 0) begin
            chk(1'b0, "R1/R8/R9 unexpected access", kind * 65536 + d, -1);
        end else begin
            e = sbq.pop_front();
            chk(e.kind == kind && e.a == a && e.d == d, e.req,
                kind * 65536 * 65536 + a * 65536 + d,
                e.kind * 65536 * 65536 + e.a * 65536 + e.d);
        end
    endtask

    // memory responder with fixed latency
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req && !mem_rd_valid) begin
                repeat (3) @(negedge clk);
                mem_rd_data  = mem_model(mem_addr);
                mem_rd_valid = 1'b1;
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end
        end
    end

    // called at a falling edge; returns at a falling edge
    task automatic send_byte(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic sync_hdr();
        send_byte(8'hFC);
        send_byte(8'hF3);
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [15:0] d);
        sync_hdr();
        send_byte(8'h3B);
        send_byte(a[15:8]); send_byte(a[7:0]);
        send_byte(d[15:8]); send_byte(d[7:0]);
    endtask

    task automatic reg_write8(input logic [7:0] i, input logic [7:0] v);
        sync_hdr();
        send_byte(8'h68); send_byte(i); send_byte(v);
    endtask

    task automatic reg_write16(input logic [7:0] i, input logic [15:0] v);
        sync_hdr();
        send_byte(8'h6A); send_byte(i); send_byte(v[15:8]); send_byte(v[7:0]);
    endtask

    task automatic reg_read(input logic [7:0] i);
        sync_hdr();
        send_byte(8'h60); send_byte(i);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        idle(8);
        chk(sbq.size() == 0, req, sbq.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  held;
        logic [15:0] rv;
        idle(3);
        #1;
        // R10 reset state
        chk(rx_ready == 1'b1, "R10 rx_ready", rx_ready, 1);
        chk(tx_valid == 1'b0 && mem_wr_en == 1'b0 && mem_rd_req == 1'b0,
            "R10 outputs idle", {tx_valid, mem_wr_en, mem_rd_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        expect_ev(1, 0, 8'h00, "R10 reg 0x10 after reset");
        reg_read(8'h10);
        expect_ev(1, 0, 8'h00, "R10 reg 0x25 after reset");
        reg_read(8'h25);
        drain("R10 drain");

        // R2 single write
        expect_ev(0, 16'h1E34, 16'h0055, "R2 mem write");
        mem_write(16'h1E34, 16'h0055);
        drain("R2 drain");

        // R3 back-to-back writes, no stall
        stalls = 0;
        expect_ev(0, 16'h0102, 16'hA0B0, "R3 burst 0");
        expect_ev(0, 16'hFFFF, 16'h0000, "R3 burst 1");
        expect_ev(0, 16'h8000, 16'h7FFF, "R3 burst 2");
        mem_write(16'h0102, 16'hA0B0);
        mem_write(16'hFFFF, 16'h0000);
        mem_write(16'h8000, 16'h7FFF);
        chk(stalls == 0, "R3 stall cycles", stalls, 0);
        drain("R3 drain");

        // R1 no sync, broken sync, then resync on repeated FC
        send_byte(8'h00); send_byte(8'hF3); send_byte(8'h3B);
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56); send_byte(8'h78);
        send_byte(8'hFC); send_byte(8'h00); send_byte(8'h3B);
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56); send_byte(8'h78);
        drain("R1 no access without sync");
        expect_ev(0, 16'h0001, 16'h0002, "R1 resync after FC FC F3");
        send_byte(8'hFC);
        mem_write(16'h0001, 16'h0002);
        drain("R1 drain");

        // R8 unknown command
        sync_hdr();
        send_byte(8'h55); send_byte(8'h3B);
        send_byte(8'h11); send_byte(8'h11); send_byte(8'h22); send_byte(8'h22);
        sync_hdr();
        send_byte(8'h00); send_byte(8'h68); send_byte(8'h05); send_byte(8'hEE);
        drain("R8 unknown command drops frame");

        // R5 short register write
        reg_write8(8'h05, 8'hA7);
        expect_ev(1, 0, 8'hA7, "R5 short write readback");
        reg_read(8'h05);
        drain("R5 drain");

        // R6 long register write
        reg_write16(8'h10, 16'h1234);
        expect_ev(1, 0, 8'h34, "R6 low byte at index");
        reg_read(8'h10);
        expect_ev(1, 0, 8'h12, "R6 high byte at index+1");
        reg_read(8'h11);
        drain("R6 drain");

        // R7 out-of-range index
        reg_write8(8'h80, 8'h99);
        expect_ev(1, 0, 8'h00, "R7 out-of-range reads zero");
        reg_read(8'h80);
        drain("R7 out-of-range drain");

        // R7 transmit hold with back-pressure
        reg_write8(8'h07, 8'hC3);
        tx_ready = 1'b0;
        sync_hdr();
        send_byte(8'h60); send_byte(8'h07);
        #1;
        held = tx_data;
        chk(tx_valid == 1'b1 && rx_ready == 1'b0, "R7 offered and rx blocked",
            {tx_valid, rx_ready}, 2'b10);
        chk(held == 8'hC3, "R7 tx byte", held, 8'hC3);
        idle(3);
        #1;
        chk(tx_valid == 1'b1 && tx_data == held, "R7 byte held", tx_data, held);
        @(negedge clk);
        expect_ev(1, 0, 8'hC3, "R7 handshake byte");
        tx_ready = 1'b1;
        drain("R7 drain");

        // R4 memory read into capture registers
        rv = mem_model(16'h1234);
        expect_ev(2, 16'h1234, 0, "R4 read request address");
        sync_hdr();
        send_byte(8'h37); send_byte(8'h12); send_byte(8'h34);
        #1;
        chk(mem_rd_req == 1'b1 && rx_ready == 1'b0, "R4 waiting, rx blocked",
            {mem_rd_req, rx_ready}, 2'b10);
        @(negedge clk);
        #1;
        chk(mem_rd_req == 1'b1 && mem_addr == 16'h1234, "R4 request held",
            mem_addr, 16'h1234);
        idle(8);
        expect_ev(1, 0, rv[7:0], "R4 low byte in 0x25");
        reg_read(8'h25);
        expect_ev(1, 0, rv[15:8], "R4 high byte in 0x26");
        reg_read(8'h26);
        drain("R4 drain");

        // R9 gap timeout
        gap_limit = 16'd16;
        sync_hdr();
        send_byte(8'h3B); send_byte(8'h20);
        idle(40);
        send_byte(8'h00); send_byte(8'h30); send_byte(8'h00); send_byte(8'h40);
        drain("R9 stalled frame discarded");
        expect_ev(0, 16'h2000, 16'h0077, "R9 short gap tolerated");
        sync_hdr();
        send_byte(8'h3B); send_byte(8'h20); send_byte(8'h00);
        idle(10);
        send_byte(8'h00); send_byte(8'h77);
        drain("R9 short gap drain");
        gap_limit = 16'd0;
        sync_hdr();
        send_byte(8'h68); send_byte(8'h09);
        idle(100);
        send_byte(8'h5A);
        expect_ev(1, 0, 8'h5A, "R9 limit zero disables timeout");
        reg_read(8'h09);
        drain("R9 disabled drain");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule